// File: doc/BRIEF.md
# Array Bounds Check Trap Unit

This unit screens array accesses before their results are allowed to take effect. Each request carries a signed subscript, a signed lower limit, an upper limit and a small unsigned immediate limit. It also carries a tag naming the access and the data word that the access produced. A two-bit mode picks the upper limit from either the limit operand or the zero-extended immediate, or it forces a trap whatever the operands are. The check normalises the range by subtracting the lower limit from both the subscript and the upper limit. One unsigned compare of the two differences then catches a subscript that sits below the range as well as one that sits above it.

Results leave through a single registered stage with a valid/ready handshake. The unit accepts one request per cycle while the consumer keeps up. Each result holds a pass flag, a two-bit error code, the request's tag and the data word. The data word is zeroed on a fault. A caller can therefore issue the access and the check together and use the returned tag to discard any later work that depended on an access that failed.

Top module: `bounds_trap_unit`

## Requirements
- R1: A synchronous active-high reset clears `out_valid`. After reset, `in_ready` is 1.
- R2: In mode 2'b00 (limit operand), an access with signed `lo <= idx <= hi` passes with code 2'b00.
- R3: A subscript below the signed lower limit fails with code 2'b01. This holds for lower limits that are zero, positive (such as 1) or negative.
- R4: A subscript above the effective upper limit, with the subscript not below the lower limit, fails with code 2'b10.
- R5: In mode 2'b01 (immediate), the upper limit is the 16-bit `in_imm` zero-extended, so the largest such limit is 65535. `in_hi` has no effect in this mode.
- R6: Any mode with bit 1 set (2'b10 or 2'b11) returns code 2'b11 for all operand values.
- R7: Each result carries the tag of the request it belongs to. Results appear in acceptance order, one cycle after acceptance at the earliest.
- R8: `out_data` equals the request's data when the access passes, and is all zeros when it faults.
- R9: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, every output holds its value.
- R10: When the lower limit exceeds the upper limit (an empty range), every checked access faults. The code is 2'b01 when the subscript is below the lower limit and 2'b10 otherwise.
- R11: `out_ok` is 1 exactly when `out_code` is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can take a request this cycle |
| in_mode | input | 2 | 00 limit operand, 01 immediate limit, 1x forced trap |
| in_idx | input | IDX_W (32) | Signed subscript |
| in_lo | input | IDX_W (32) | Signed lower limit |
| in_hi | input | IDX_W (32) | Signed upper limit (mode 00) |
| in_imm | input | IMM_W (16) | Unsigned immediate upper limit (mode 01) |
| in_tag | input | TAG_W (8) | Tag identifying the access |
| in_data | input | DATA_W (32) | Data word produced by the access |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_ok | output | 1 | Access passed the check |
| out_code | output | 2 | 00 ok, 01 below lower, 10 above upper, 11 forced trap |
| out_tag | output | TAG_W (8) | Tag of the reported access |
| out_data | output | DATA_W (32) | Data word when ok, zero on fault |

## Verification
The bench uses the default widths: a 32-bit subscript and limits, a 16-bit immediate, an 8-bit tag and 32-bit data. With these widths it can reach both extremes of the signed range. It exercises the wrap of a subscript below a negative lower limit, and it places the immediate limit exactly at 65535 and one past it. A consumer that drops `out_ready` every fifth cycle brings the hold-while-stalled behaviour and acceptance ordering under test together with empty ranges and both trap encodings.

// File: rtl/bchk_pkg.sv
package bchk_pkg;

  typedef enum logic [1:0] {
    MODE_REG  = 2'b00,
    MODE_IMM  = 2'b01,
    MODE_TRAP = 2'b10,
    MODE_TRP2 = 2'b11
  } bchk_mode_e;

  typedef enum logic [1:0] {
    CODE_OK    = 2'b00,
    CODE_BELOW = 2'b01,
    CODE_ABOVE = 2'b10,
    CODE_TRAP  = 2'b11
  } bchk_code_e;

endpackage

// File: rtl/bchk_limit_sel.sv
module bchk_limit_sel #(
  parameter int IDX_W = 32,
  parameter int IMM_W = 16
) (
  input  logic [1:0]       mode,
  input  logic [IDX_W-1:0] hi,
  input  logic [IMM_W-1:0] imm,
  output logic [IDX_W-1:0] hi_eff
);
  import bchk_pkg::*;

  logic [IDX_W-1:0] imm_ext;

  // zero-extend (or clip) the immediate to the subscript width
  generate
    if (IMM_W < IDX_W) begin : g_pad
      localparam int PAD_W = IDX_W - IMM_W;
      assign imm_ext = {{PAD_W{1'b0}}, imm};
    end else begin : g_clip
      assign imm_ext = imm[IDX_W-1:0];
    end
  endgenerate

  always_comb begin
    hi_eff = (mode == MODE_IMM) ? imm_ext : hi;
  end

endmodule

// File: rtl/bchk_check_core.sv
module bchk_check_core #(
  parameter int IDX_W = 32
) (
  input  logic [1:0]       mode,
  input  logic [IDX_W-1:0] idx,
  input  logic [IDX_W-1:0] lo,
  input  logic [IDX_W-1:0] hi_eff,
  output logic [1:0]       code,
  output logic             pass
);
  import bchk_pkg::*;

  logic [IDX_W-1:0] offs;
  logic [IDX_W-1:0] span;
  logic             empty_rng;
  logic             outside;
  logic             under;

  always_comb begin
    // shift the window so it starts at zero; a subscript under the
    // lower limit wraps to a large unsigned offset
    offs      = idx - lo;
    span      = hi_eff - lo;
    empty_rng = $signed(lo) > $signed(hi_eff);
    outside   = (offs > span) || empty_rng;
    under     = $signed(idx) < $signed(lo);

    if (mode[1])
      code = CODE_TRAP;
    else if (!outside)
      code = CODE_OK;
    else if (under)
      code = CODE_BELOW;
    else
      code = CODE_ABOVE;

    pass = !mode[1] && !outside;
  end

endmodule

// File: rtl/bchk_result_reg.sv
module bchk_result_reg #(
  parameter int TAG_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              d_ok,
  input  logic [1:0]        d_code,
  input  logic [TAG_W-1:0]  d_tag,
  input  logic [DATA_W-1:0] d_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_ok,
  output logic [1:0]        out_code,
  output logic [TAG_W-1:0]  out_tag,
  output logic [DATA_W-1:0] out_data
);
  import bchk_pkg::*;

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid && in_ready) begin
      out_ok   <= d_ok;
      out_code <= d_code;
      out_tag  <= d_tag;
      out_data <= d_data;
    end
  end

  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_code) &&
                                   $stable(out_tag) && $stable(out_data) &&
                                   $stable(out_ok)));

  // R11
  ok_matches_code_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_ok == (out_code == CODE_OK)));

  // R8
  fault_data_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ok) |-> (out_data == '0));

endmodule

// File: rtl/bounds_trap_unit.sv
module bounds_trap_unit #(
  parameter int IDX_W  = 32,
  parameter int IMM_W  = 16,
  parameter int TAG_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        in_mode,
  input  logic [IDX_W-1:0]  in_idx,
  input  logic [IDX_W-1:0]  in_lo,
  input  logic [IDX_W-1:0]  in_hi,
  input  logic [IMM_W-1:0]  in_imm,
  input  logic [TAG_W-1:0]  in_tag,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_ok,
  output logic [1:0]        out_code,
  output logic [TAG_W-1:0]  out_tag,
  output logic [DATA_W-1:0] out_data
);
  import bchk_pkg::*;

  logic [IDX_W-1:0]  hi_eff;
  logic [1:0]        chk_code;
  logic              chk_pass;
  logic [DATA_W-1:0] gated_data;

  bchk_limit_sel #(.IDX_W(IDX_W), .IMM_W(IMM_W)) u_lim (
    .mode   (in_mode),
    .hi     (in_hi),
    .imm    (in_imm),
    .hi_eff (hi_eff)
  );

  bchk_check_core #(.IDX_W(IDX_W)) u_core (
    .mode   (in_mode),
    .idx    (in_idx),
    .lo     (in_lo),
    .hi_eff (hi_eff),
    .code   (chk_code),
    .pass   (chk_pass)
  );

  assign gated_data = chk_pass ? in_data : '0;

  bchk_result_reg #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_out (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .d_ok      (chk_pass),
    .d_code    (chk_code),
    .d_tag     (in_tag),
    .d_data    (gated_data),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_ok    (out_ok),
    .out_code  (out_code),
    .out_tag   (out_tag),
    .out_data  (out_data)
  );

  // R6
  trap_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_mode[1]) |=> (out_valid && out_code == CODE_TRAP));

  // R7
  tag_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (out_valid && out_tag == $past(in_tag)));

endmodule

// File: tb/tb_bounds_trap_unit.sv
module tb_bounds_trap_unit;

  localparam int IDX_W  = 32;
  localparam int IMM_W  = 16;
  localparam int TAG_W  = 8;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [1:0]        in_mode = '0;
  logic [IDX_W-1:0]  in_idx = '0;
  logic [IDX_W-1:0]  in_lo = '0;
  logic [IDX_W-1:0]  in_hi = '0;
  logic [IMM_W-1:0]  in_imm = '0;
  logic [TAG_W-1:0]  in_tag = '0;
  logic [DATA_W-1:0] in_data = '0;
  logic              out_valid;
  logic              out_ready;
  logic              out_ok;
  logic [1:0]        out_code;
  logic [TAG_W-1:0]  out_tag;
  logic [DATA_W-1:0] out_data;

  always #10 clk = ~clk;

  bounds_trap_unit #(.IDX_W(IDX_W), .IMM_W(IMM_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_mode(in_mode), .in_idx(in_idx), .in_lo(in_lo), .in_hi(in_hi),
    .in_imm(in_imm), .in_tag(in_tag), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_ok(out_ok),
    .out_code(out_code), .out_tag(out_tag), .out_data(out_data)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [1:0]        q_code[$];
  logic [TAG_W-1:0]  q_tag[$];
  logic [DATA_W-1:0] q_data[$];
  string             q_req[$];

  logic [TAG_W-1:0] next_tag = 8'h01;

  task automatic check(input string req, input bit ok, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [1:0] model(input logic [1:0] mode,
      input logic signed [IDX_W-1:0] idx, input logic signed [IDX_W-1:0] lo,
      input logic signed [IDX_W-1:0] hi, input logic [IMM_W-1:0] imm);
    logic signed [IDX_W:0] top;
    if (mode[1]) return 2'b11;
    top = (mode == 2'b01) ? $signed({1'b0, {(IDX_W-IMM_W){1'b0}}, imm})
                          : $signed({hi[IDX_W-1], hi});
    if (idx < lo) return 2'b01;
    if ($signed({idx[IDX_W-1], idx}) > top) return 2'b10;
    return 2'b00;
  endfunction

  task automatic send(input string req, input logic [1:0] mode,
                      input logic [IDX_W-1:0] idx, input logic [IDX_W-1:0] lo,
                      input logic [IDX_W-1:0] hi, input logic [IMM_W-1:0] imm,
                      input logic [DATA_W-1:0] data);
    logic [1:0] c;
    @(negedge clk); #1;
    c = model(mode, idx, lo, hi, imm);
    in_mode = mode; in_idx = idx; in_lo = lo; in_hi = hi; in_imm = imm;
    in_tag = next_tag; in_data = data; in_valid = 1'b1;
    q_code.push_back(c);
    q_tag.push_back(next_tag);
    q_data.push_back(c == 2'b00 ? data : '0);
    q_req.push_back(req);
    next_tag = next_tag + 1'b1;
    while (!in_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  // monitor / scoreboard
  int cyc = 0;
  bit stall_prev = 0;
  logic [1:0]        s_code;
  logic [TAG_W-1:0]  s_tag;
  logic [DATA_W-1:0] s_data;
  initial begin
    out_ready = 1'b0;
    forever begin
      @(negedge clk);
      cyc++;
      out_ready = (cyc % 5) != 3;
      #2;
      if (!rst) begin
        if (stall_prev) begin
          check("R9", out_valid && out_code == s_code && out_tag == s_tag &&
                out_data == s_data, "held tag", longint'(out_tag), longint'(s_tag));
        end
        stall_prev = out_valid && !out_ready;
        s_code = out_code; s_tag = out_tag; s_data = out_data;
        if (out_valid && out_ready) begin
          if (q_code.size() == 0) begin
            check("R7", 1'b0, "unexpected result tag", longint'(out_tag), 0);
          end else begin
            logic [1:0] ec; logic [TAG_W-1:0] et; logic [DATA_W-1:0] ed; string er;
            ec = q_code.pop_front(); et = q_tag.pop_front();
            ed = q_data.pop_front(); er = q_req.pop_front();
            check(er, out_code == ec, "code", longint'(out_code), longint'(ec));
            check("R7", out_tag == et, "tag", longint'(out_tag), longint'(et));
            check("R8", out_data == ed, "data", longint'(out_data), longint'(ed));
            check("R11", out_ok == (ec == 2'b00), "ok", longint'(out_ok),
                  longint'(ec == 2'b00));
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] lcg;
    repeat (3) @(posedge clk);
    #1;
    check("R1", out_valid == 1'b0, "out_valid in reset", longint'(out_valid), 0);
    @(negedge clk); rst = 1'b0;
    @(negedge clk); #3;
    check("R1", in_ready == 1'b1 || !out_ready, "in_ready after reset",
          longint'(in_ready), 1);
    check("R1", out_valid == 1'b0, "out_valid after reset", longint'(out_valid), 0);

    // R2 passes
    send("R2", 2'b00, 32'd9, 32'd0, 32'd9, 16'd0, 32'hA000_0001);
    send("R2", 2'b00, 32'd0, 32'd0, 32'd9, 16'd0, 32'hA000_0002);
    // R4 above
    send("R4", 2'b00, 32'd10, 32'd0, 32'd9, 16'd0, 32'hA000_0003);
    // R3 below, zero / one / negative lower limit
    send("R3", 2'b00, 32'hFFFF_FFFF, 32'd0, 32'd9, 16'd0, 32'hA000_0004);
    send("R2", 2'b00, 32'd1, 32'd1, 32'd10, 16'd0, 32'hA000_0005);
    send("R3", 2'b00, 32'd0, 32'd1, 32'd10, 16'd0, 32'hA000_0006);
    send("R2", 2'b00, -32'sd5, -32'sd5, 32'd5, 16'd0, 32'hA000_0007);
    send("R3", 2'b00, -32'sd6, -32'sd5, 32'd5, 16'd0, 32'hA000_0008);
    send("R4", 2'b00, 32'd6, -32'sd5, 32'd5, 16'd0, 32'hA000_0009);
    // signed extremes
    send("R2", 2'b00, 32'h7FFF_FFFF, 32'h8000_0000, 32'h7FFF_FFFF, 16'd0, 32'hA000_000A);
    send("R3", 2'b00, 32'h8000_0000, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 16'd0, 32'hA000_000B);
    // R5 immediate limit, in_hi ignored
    send("R5", 2'b01, 32'd65535, 32'd0, 32'd3, 16'hFFFF, 32'hA000_000C);
    send("R5", 2'b01, 32'd65536, 32'd0, 32'h7FFF_FFFF, 16'hFFFF, 32'hA000_000D);
    send("R5", 2'b01, 32'd0, 32'd0, 32'hFFFF_FFFF, 16'd0, 32'hA000_000E);
    send("R5", 2'b01, 32'd1, 32'd0, 32'd100, 16'd0, 32'hA000_000F);
    // R6 forced trap, both encodings
    send("R6", 2'b10, 32'd3, 32'd0, 32'd9, 16'd9, 32'hA000_0010);
    send("R6", 2'b11, 32'd3, 32'd0, 32'd9, 16'd9, 32'hA000_0011);
    // R10 empty range
    send("R10", 2'b00, 32'd3, 32'd5, 32'd2, 16'd0, 32'hA000_0012);
    send("R10", 2'b00, 32'd6, 32'd5, 32'd2, 16'd0, 32'hA000_0013);
    send("R10", 2'b00, 32'd5, 32'd5, 32'd2, 16'd0, 32'hA000_0014);

    // mixed burst
    lcg = 32'h1234_5678;
    for (int i = 0; i < 60; i++) begin
      logic [31:0] a, b, c;
      lcg = lcg * 32'd1664525 + 32'd1013904223; a = {24'd0, lcg[31:24]} - 32'd40;
      lcg = lcg * 32'd1664525 + 32'd1013904223; b = {24'd0, lcg[31:24]} - 32'd100;
      lcg = lcg * 32'd1664525 + 32'd1013904223; c = {24'd0, lcg[31:24]};
      send((model(lcg[1:0], a, b, c, c[15:0]) == 2'b00) ? "R2" :
           (lcg[1] ? "R6" : "R4"), lcg[1:0], a, b, c, c[15:0], lcg);
    end

    for (int k = 0; k < 200 && q_code.size() != 0; k++) @(negedge clk);
    check("R7", q_code.size() == 0, "results outstanding",
          longint'(q_code.size()), 0);
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule